// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Reset Sequencer

A single-clock FIFO for 36-bit words whose read timing is picked once after every reset. While reset is low the block holds all status outputs in a fixed state. On the first rising clock edge after release it latches the level of a mode-select pin. On the second edge it opens the write side. The chosen mode then stays fixed until the next reset, whatever the pin does.

In standard mode the read-valid output acts as an active-low empty flag and the write-ready output acts as an active-low full flag. Every word, the first one included, has to be pulled out with a read request, and it appears on the output one edge after that request. In fall-through mode the head word is moved into an output register without any request. The read-valid output then means "data on the output is valid", and write-ready means "there is free space". An almost-empty flag and an almost-full flag, both active low, are compared against two offset inputs. Writes that arrive with no room, and reads that arrive with nothing to give, are ignored.

Top module: `dmfifo`

## Requirements
- R1: While rst_n is low: wr_room = 0, rd_avail = 0, almost_empty_n = 0, almost_full_n = 1 and rd_data = 0.
- R2: After rst_n rises, wr_room and rd_avail stay low through the first rising clock edge. wr_room goes high at the second rising edge, and write and read requests before that edge are ignored.
- R3: The std_sel level at the first rising edge after reset release chooses the mode (1 = standard, 0 = fall-through). Later changes on std_sel have no effect until the next reset.
- R4: In standard mode, rd_avail is 1 exactly when at least one word is stored. A read with rd_avail high puts the oldest word on rd_data at that clock edge and removes it.
- R5: In standard mode, wr_room is 1 exactly when fewer than DEPTH words are stored. A write with wr_room high stores wr_data at that edge.
- R6: In fall-through mode, a word written into an empty FIFO appears on rd_data with rd_avail high one edge after the write edge, with no read request.
- R7: In fall-through mode, a read with rd_avail high consumes the presented word. The next stored word, if there is one, is presented at that same edge. wr_room is 1 exactly when the stored count, including the presented word, is below DEPTH.
- R8: A write with wr_room low is dropped. A read with rd_avail low changes neither rd_data nor the stored contents.
- R9: Once running, almost_empty_n is 0 exactly when the stored count is less than or equal to x_off.
- R10: Once running, almost_full_n is 0 exactly when DEPTH minus the stored count is less than or equal to y_off. Before the second edge after release it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert and release |
| std_sel | input | 1 | Mode select, sampled once after reset (1 standard, 0 fall-through) |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Write word |
| wr_room | output | 1 | Write accepted if high (not-full / input-ready) |
| rd_en | input | 1 | Read request |
| rd_data | output | W | Read word |
| rd_avail | output | 1 | Read possible if high (not-empty / output-ready) |
| x_off | input | AW | Almost-empty offset |
| y_off | input | AW | Almost-full offset |
| almost_empty_n | output | 1 | Low when stored count <= x_off |
| almost_full_n | output | 1 | Low when free space <= y_off |

## Verification
The hardest situation to reach is a fall-through FIFO that is exactly full while a word sits in the output register. In that state a simultaneous read must both free a slot and present the next word at the same edge. The bench reaches it by reducing DEPTH to 16 and running a write-heavy burst driven by a pseudo-random pattern, which saturates the FIFO, and then switching to a read-heavy burst. Toggling std_sel in the middle of a run, after release, checks that the frozen mode survives pin activity.

// File: rtl/dmfifo_pkg.sv
package dmfifo_pkg;
  typedef enum logic {MODE_FALL = 1'b0, MODE_STD = 1'b1} rdmode_e;
  typedef enum logic [1:0] {SEQ_HOLD = 2'd0, SEQ_ARM = 2'd1, SEQ_RUN = 2'd2} seq_e;

  // true when a <= b
  function automatic logic le_u32(logic [31:0] a, logic [31:0] b);
    return a <= b;
  endfunction

  // free slots for a given occupancy
  function automatic logic [31:0] free_of(logic [31:0] depth, logic [31:0] used);
    return depth - used;
  endfunction
endpackage

// File: rtl/dmf_rst_seq.sv
module dmf_rst_seq
  import dmfifo_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    std_sel,
  output logic    run,
  output rdmode_e mode
);
  seq_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_HOLD;
      mode  <= MODE_STD;
    end else begin
      case (state)
        SEQ_HOLD: begin
          mode  <= std_sel ? MODE_STD : MODE_FALL;
          state <= SEQ_ARM;
        end
        SEQ_ARM: state <= SEQ_RUN;
        default: state <= SEQ_RUN;
      endcase
    end
  end

  assign run = (state == SEQ_RUN);
endmodule

// File: rtl/dmf_store.sv
module dmf_store
  import dmfifo_pkg::*;
#(
  parameter int W     = 36,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  rdmode_e       mode,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic          wr_room,
  output logic          rd_avail,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] total,
  output logic          wr_fire,
  output logic          rd_fire
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] mcnt;
  logic          oval;
  logic          is_std;
  logic          pop;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign is_std   = (mode == MODE_STD);
  assign total    = is_std ? mcnt : mcnt + CW'(oval);
  assign wr_room  = run && (total < CW'(DEPTH));
  assign rd_avail = run && (is_std ? (mcnt != '0) : oval);
  assign wr_fire  = wr_en && wr_room;
  assign rd_fire  = rd_en && rd_avail;
  // standard: pop on request; fall-through: refill an empty or consumed output stage
  assign pop      = is_std ? rd_fire : (run && (!oval || rd_fire) && (mcnt != '0));

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      mcnt    <= '0;
      oval    <= 1'b0;
      rd_data <= '0;
    end else if (run) begin
      if (wr_fire) wptr <= bump(wptr);
      if (pop) begin
        rptr    <= bump(rptr);
        rd_data <= mem[rptr];
      end
      mcnt <= mcnt + CW'(wr_fire) - CW'(pop);
      if (!is_std) oval <= pop ? 1'b1 : (rd_fire ? 1'b0 : oval);
    end
  end
endmodule

// File: rtl/dmf_flags.sv
module dmf_flags
  import dmfifo_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
)(
  input  logic          run,
  input  logic [CW-1:0] total,
  input  logic [AW-1:0] x_off,
  input  logic [AW-1:0] y_off,
  output logic          almost_empty_n,
  output logic          almost_full_n
);
  logic near_empty, near_full;

  assign near_empty = le_u32(32'(total), 32'(x_off));
  assign near_full  = le_u32(free_of(DEPTH, 32'(total)), 32'(y_off));

  assign almost_empty_n = run ? !near_empty : 1'b0;
  assign almost_full_n  = run ? !near_full  : 1'b1;
endmodule

// File: rtl/dmfifo.sv
module dmfifo
  import dmfifo_pkg::*;
#(
  parameter int W     = 36,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          std_sel,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic          wr_room,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          rd_avail,
  input  logic [AW-1:0] x_off,
  input  logic [AW-1:0] y_off,
  output logic          almost_empty_n,
  output logic          almost_full_n
);
  logic          seq_ready;
  rdmode_e       mode;
  logic          mode_std;
  logic [CW-1:0] cnt_total;
  logic          wr_fire, rd_fire;

  dmf_rst_seq u_seq (
    .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .run(seq_ready), .mode(mode)
  );

  assign mode_std = (mode == MODE_STD);

  dmf_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .run(seq_ready), .mode(mode),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .wr_room(wr_room), .rd_avail(rd_avail), .rd_data(rd_data),
    .total(cnt_total), .wr_fire(wr_fire), .rd_fire(rd_fire)
  );

  dmf_flags #(.DEPTH(DEPTH)) u_flags (
    .run(seq_ready), .total(cnt_total), .x_off(x_off), .y_off(y_off),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
  );
endmodule

// File: rtl/dmfifo_chk.sv
module dmfifo_chk #(
  parameter int W     = 36,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
)(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_room,
  input logic          rd_en,
  input logic          rd_avail,
  input logic [W-1:0]  rd_data,
  input logic          almost_empty_n,
  input logic          almost_full_n,
  input logic          seq_ready,
  input logic          mode_std,
  input logic [CW-1:0] cnt_total,
  input logic          rd_fire
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (!wr_room && !rd_avail && !almost_empty_n && almost_full_n));

  // R2
  ready_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |=> (!seq_ready && !wr_room));

  // R2
  ready_on_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |=> ##1 seq_ready);

  // R3
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_ready |=> $stable(mode_std));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_total <= CW'(DEPTH));

  // R8
  drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_room && !rd_fire) |=> $stable(cnt_total));

  // R8
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_std && rd_en && !rd_avail) |=> $stable(rd_data));

  // R9
  empty_is_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_ready && mode_std && !rd_avail) |-> !almost_empty_n);

  // R10
  full_is_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_ready && !wr_room) |-> !almost_full_n);
endmodule

bind dmfifo dmfifo_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_room(wr_room),
  .rd_en(rd_en), .rd_avail(rd_avail), .rd_data(rd_data),
  .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n),
  .seq_ready(seq_ready), .mode_std(mode_std), .cnt_total(cnt_total),
  .rd_fire(rd_fire)
);

// File: tb/test_dmfifo.sv
`timescale 1ns/1ps
module test_dmfifo;
  localparam int W = 36;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic std_sel = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [AW-1:0] x_off = AW'(3), y_off = AW'(2);
  logic wr_room, rd_avail, almost_empty_n, almost_full_n;
  logic [W-1:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit live = 0, done = 0;

  dmfifo #(.W(W), .DEPTH(DEPTH)) i_dmfifo (
    .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .wr_en(wr_en), .wr_data(wr_data),
    .wr_room(wr_room), .rd_en(rd_en), .rd_data(rd_data), .rd_avail(rd_avail),
    .x_off(x_off), .y_off(y_off),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
  );

  always #2 clk = ~clk;

  // behavioural reference
  int phase = 0;
  bit m_std = 1;
  logic [W-1:0] q[$];
  bit m_oval = 0;
  logic [W-1:0] m_dout = '0;

  function automatic int m_total();
    return q.size() + ((!m_std && m_oval) ? 1 : 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; q.delete(); m_oval = 0; m_dout = '0;
    end else if (phase == 0) begin
      m_std = std_sel; phase = 1;
    end else if (phase == 1) begin
      phase = 2;
    end else begin
      automatic bit wok = wr_en && (m_total() < DEPTH);
      if (m_std) begin
        if (rd_en && q.size() > 0) m_dout = q.pop_front();
      end else begin
        automatic bit rok = rd_en && m_oval;
        automatic bit load = (!m_oval || rok) && q.size() > 0;
        if (rok) m_oval = 0;
        if (load) begin m_dout = q.pop_front(); m_oval = 1; end
      end
      if (wok) q.push_back(wr_data);
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      if (!rst_n) begin
        chk("R1 wr_room", 64'(wr_room), 0);
        chk("R1 rd_avail", 64'(rd_avail), 0);
        chk("R1 almost_empty_n", 64'(almost_empty_n), 0);
        chk("R1 almost_full_n", 64'(almost_full_n), 1);
        chk("R1 rd_data", 64'(rd_data), 0);
      end else begin
        automatic bit run = (phase == 2);
        automatic int t = m_total();
        chk(run ? (m_std ? "R5 wr_room" : "R7 wr_room") : "R2 wr_room",
            64'(wr_room), 64'(run && t < DEPTH));
        chk(run ? (m_std ? "R4 rd_avail" : "R6 rd_avail") : "R2 rd_avail",
            64'(rd_avail), 64'(run && (m_std ? q.size() > 0 : m_oval)));
        chk(m_std ? "R4 rd_data" : "R7 rd_data", 64'(rd_data), 64'(m_dout));
        chk("R9 almost_empty_n", 64'(almost_empty_n), 64'(run && !(t <= int'(x_off))));
        chk("R10 almost_full_n", 64'(almost_full_n), 64'(!(run && (DEPTH - t) <= int'(y_off))));
      end
    end
  end

  task automatic step(bit we, logic [W-1:0] wd, bit re);
    @(negedge clk); #1;
    wr_en = we; wr_data = wd; rd_en = re;
  endtask

  task automatic do_reset(bit mode);
    @(negedge clk); #1;
    wr_en = 0; rd_en = 0; rst_n = 0; std_sel = mode;
    repeat (5) @(negedge clk);
    #1 rst_n = 1;
  endtask

  int unsigned lfsr = 32'h1234_5678;
  function automatic int unsigned nxt(int unsigned v);
    v ^= v << 13; v ^= v >> 17; v ^= v << 5;
    return v;
  endfunction

  initial begin
    #1 rst_n = 0; live = 1;
    // standard mode
    do_reset(1'b1);
    step(1, 36'hA_0000_0001, 0);   // R2: dropped, not yet running
    step(0, 0, 1);
    step(0, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 36'h1_0000_0000 + W'(i), 0);
    std_sel = 0;                  // R3: must have no effect
    for (int i = 0; i < 5; i++) step(0, 0, 1);
    step(0, 0, 1);                // R8: read on empty
    step(0, 0, 0);
    @(negedge clk); #0.5;
    chk("R8 idle read keeps data", 64'(rd_data), 64'(36'h1_0000_0004));
    for (int i = 0; i < DEPTH + 3; i++) step(1, 36'h2_0000_0000 + W'(i), 0);
    x_off = '0; y_off = '0;
    step(1, 36'h3, 1);            // full: read and write together
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 1);
    step(0, 0, 0);
    x_off = AW'(3); y_off = AW'(2);

    // fall-through mode
    do_reset(1'b0);
    step(0, 0, 0);
    step(0, 0, 0);
    step(1, 36'hF_EED0_0001, 0);
    step(0, 0, 0);
    @(negedge clk); #0.5;
    chk("R6 first word falls through", 64'(rd_data), 64'(36'hF_EED0_0001));
    chk("R6 output ready without read", 64'(rd_avail), 1);
    std_sel = 1;                  // R3: still fall-through
    step(0, 0, 1);
    step(1, 36'h5_5555_0002, 0);
    step(0, 0, 0);
    @(negedge clk); #0.5;
    chk("R3 mode kept after pin change", 64'(rd_avail), 1);
    chk("R3 word presented without read", 64'(rd_data), 64'(36'h5_5555_0002));
    for (int i = 0; i < 120; i++) begin
      lfsr = nxt(lfsr);
      step((lfsr[1:0] != 0), W'(lfsr), (lfsr[3:2] == 0));
    end
    for (int i = 0; i < 120; i++) begin
      lfsr = nxt(lfsr);
      step((lfsr[1:0] == 0), W'(lfsr), (lfsr[3:2] != 0));
    end
    for (int i = 0; i < DEPTH + 4; i++) step(1, 36'h7_0000_0000 + W'(i), 0);
    for (int i = 0; i < 6; i++) step(1, 36'h8_0000_0000 + W'(i), 1);
    for (int i = 0; i < DEPTH + 4; i++) step(0, 0, 1);
    step(0, 0, 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule